// File: doc/BRIEF.md
# Byte-Serial CRC-32 Engine (Polynomial 0x20044009)

This block computes a 32-bit cyclic redundancy check over a stream of bytes, one byte per clock. It uses a generator polynomial that differs from the common Ethernet one: x^32 + x^29 + x^18 + x^14 + x^3 + 1, written 0x20044009 with the x^32 term left implicit. Bits are processed most significant first. Neither the data nor the result is bit-reflected, and no final XOR is applied. The checksum is meant to protect command descriptor blocks. Placing it inside those blocks is left to the surrounding logic.

A message starts with a load strobe that carries a start value. A fresh message uses 0xFFFFFFFF. A value saved earlier continues a CRC that was interrupted. Each byte presented with its valid flag is folded into the running value, and the new value appears at the output on the next clock edge. If the load and a byte arrive in the same cycle, the byte is applied on top of the value being loaded.

The update logic is chosen at elaboration time. One option is an 8-step unrolled shift network. The other is a 256-entry lookup table that is computed during elaboration. Both give the same result.

Top module: `crc32_byte_engine`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the output becomes 0xFFFFFFFF at that edge.
- R2: Each byte is folded in most significant bit first with polynomial 0x20044009. For every bit, the register shifts left by one; if the bit leaving position 31, XORed with the incoming data bit, was 1, the register is also XORed with 0x20044009. There is no reflection and no final XOR, so a zero byte folded into a zero value leaves zero.
- R3: One byte is accepted in every cycle where byte-valid is high, including back-to-back cycles. The updated value appears on the output one clock after acceptance.
- R4: Starting from 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 in that order give 0xF33CB7D3.
- R5: In a cycle with neither load nor byte-valid, the output keeps its value, whatever is on the data bus.
- R6: A load without a byte sets the output to the load value one clock later.
- R7: A load and a byte in the same cycle produce the load value with that byte folded in.
- R8: Loading a saved intermediate value and feeding the remaining bytes gives the same result as one uninterrupted stream.
- R9: For a zero-length message (a load with no bytes after it), the output equals the load value and stays there.
- R10: The table-based and the unrolled update variants give identical outputs for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_i | input | 1 | Load strobe for the start value |
| init_val_i | input | 32 | Start value taken when init_i is high |
| byte_vld_i | input | 1 | The byte on byte_i is accepted this cycle |
| byte_i | input | 8 | Data byte |
| crc_o | output | 32 | Running CRC value |

## Verification
The hardest case to reach is a load and a byte arriving in the same cycle, with the load value different from the value already held. Only then does the choice between the old and the new value as the base of the update become visible. The stimulus sweeps all 256 byte values through this path, each time with an unrelated random load value. Continuation is reached by saving an intermediate result and then running an unrelated message to disturb the register. The saved value is then reloaded, and the remaining bytes must match the result of the uninterrupted stream. Both update variants run side by side on the same inputs.

// File: rtl/crc32_pkg.sv
// Package: shared widths, types and the bit-serial advance function for the
// byte CRC engine. Assumes a CRC no wider than 64 bits and a data byte
// narrower than the CRC.
package crc32_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int TBL_N  = 2 ** BYTE_W;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        UPD_UNROLLED = 1'b0,
        UPD_TABLE    = 1'b1
    } upd_kind_e;

    // Fold one data byte into a CRC value, MSB first, no reflection.
    function automatic crc_t crc_advance(crc_t crc, byte_t data, crc_t poly);
        crc_t c;
        c = crc ^ (crc_t'(data) << (CRC_W - BYTE_W));
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[CRC_W-1] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_upd_unrolled.sv
// Module: combinational byte update built as BYTE_W chained shift/XOR steps.
// Assumes: pure combinational; the caller registers the result.
module crc_upd_unrolled
    import crc32_pkg::*;
#(
    parameter crc_t POLY = 32'h2004_4009
) (
    input  crc_t  crc_i,
    input  byte_t byte_i,
    output crc_t  crc_o
);

    crc_t stage [BYTE_W+1];

    // Seed the chain with the byte aligned under the CRC's top bits.
    always_comb begin
        stage[0] = crc_i ^ (crc_t'(byte_i) << (CRC_W - BYTE_W));
    end

    genvar s;
    generate
        for (s = 0; s < BYTE_W; s++) begin : g_step
            // One polynomial division step per data bit.
            always_comb begin
                stage[s+1] = stage[s][CRC_W-1] ? ((stage[s] << 1) ^ POLY)
                                               : (stage[s] << 1);
            end
        end
    endgenerate

    assign crc_o = stage[BYTE_W];

endmodule

// File: rtl/crc_upd_table.sv
// Module: combinational byte update through a lookup table whose entries are
// computed at elaboration time: next = (crc << 8) ^ T[crc_top ^ byte].
// Assumes: pure combinational; TBL_N constants become logic in synthesis.
module crc_upd_table
    import crc32_pkg::*;
#(
    parameter crc_t POLY = 32'h2004_4009
) (
    input  crc_t  crc_i,
    input  byte_t byte_i,
    output crc_t  crc_o
);

    crc_t  tbl [TBL_N];
    byte_t idx;

    genvar g;
    generate
        for (g = 0; g < TBL_N; g++) begin : g_entry
            localparam crc_t ENTRY = crc_advance('0, byte_t'(g), POLY);
            assign tbl[g] = ENTRY;
        end
    endgenerate

    // Index from the outgoing top byte combined with the new data byte.
    always_comb begin
        idx = crc_i[CRC_W-1 -: BYTE_W] ^ byte_i;
    end

    // Shift the remainder up by one byte and merge the table entry.
    always_comb begin
        crc_o = (crc_i << BYTE_W) ^ tbl[idx];
    end

endmodule

// File: rtl/crc_state.sv
// Module: running CRC register with base selection. Priority: reset, then a
// byte (folded on the load value if a load is present), then a bare load.
// Assumes: synchronous active-low reset; the next value comes from an
// external update network fed with base_o.
module crc_state
    import crc32_pkg::*;
#(
    parameter crc_t RST_VAL = 32'hFFFF_FFFF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init_i,
    input  crc_t  init_val_i,
    input  logic  vld_i,
    input  byte_t byte_i,
    input  crc_t  next_i,
    output crc_t  base_o,
    output crc_t  crc_q
);

    // Base of the update: a load in this cycle takes precedence over state.
    always_comb begin
        base_o = init_i ? init_val_i : crc_q;
    end

    // State register: changes only on reset, byte or load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= RST_VAL;
        end else if (vld_i) begin
            crc_q <= next_i;
        end else if (init_i) begin
            crc_q <= init_val_i;
        end
    end

    p_reset_val_r1: assert property (@(posedge clk)
        !rst_n |=> crc_q == RST_VAL)
        else $error("R1: reset value wrong");

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !vld_i) |=> $stable(crc_q))
        else $error("R5: value moved without strobe");

    p_init_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && !vld_i) |=> crc_q == $past(init_val_i))
        else $error("R6: load value not taken");

    p_zero_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && base_o == '0 && byte_i == '0) |=> crc_q == '0)
        else $error("R2: zero not preserved");

endmodule

// File: rtl/crc32_byte_engine.sv
// Module: top of the byte-serial CRC engine. Selects the update network by
// parameter and wraps the running register.
// Assumes: one byte per clock at most; no final inversion or reflection.
module crc32_byte_engine
    import crc32_pkg::*;
#(
    parameter crc_t      POLY    = 32'h2004_4009,
    parameter crc_t      RST_VAL = 32'hFFFF_FFFF,
    parameter upd_kind_e UPD     = UPD_UNROLLED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [CRC_W-1:0]  init_val_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);

    crc_t base;
    crc_t next;
    crc_t crc_q;

    generate
        if (UPD == UPD_TABLE) begin : g_tbl
            crc_upd_table #(.POLY(POLY)) u_upd (
                .crc_i (base),
                .byte_i(byte_i),
                .crc_o (next)
            );
        end else begin : g_unr
            crc_upd_unrolled #(.POLY(POLY)) u_upd (
                .crc_i (base),
                .byte_i(byte_i),
                .crc_o (next)
            );
        end
    endgenerate

    crc_state #(.RST_VAL(RST_VAL)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .init_val_i(init_val_i),
        .vld_i     (byte_vld_i),
        .byte_i    (byte_i),
        .next_i    (next),
        .base_o    (base),
        .crc_q     (crc_q)
    );

    assign crc_o = crc_q;

endmodule

// File: tb/crc32_byte_engine_bench.sv
// Bench: drives both update variants with identical stimulus and checks them
// against a bit-at-a-time reference written from the requirements.
module crc32_byte_engine_bench;

    localparam logic [31:0] POLY = 32'h2004_4009;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic [31:0] init_val = '0;
    logic        vld = 1'b0;
    logic [7:0]  data = '0;
    logic [31:0] crc_u;
    logic [31:0] crc_t;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    crc32_byte_engine u_crc32_byte_engine (
        .clk(clk), .rst_n(rst_n), .init_i(init), .init_val_i(init_val),
        .byte_vld_i(vld), .byte_i(data), .crc_o(crc_u)
    );

    crc32_byte_engine #(.UPD(crc32_pkg::UPD_TABLE)) u_crc32_byte_engine_tbl (
        .clk(clk), .rst_n(rst_n), .init_i(init), .init_val_i(init_val),
        .byte_vld_i(vld), .byte_i(data), .crc_o(crc_t)
    );

    // Reference: one data bit at a time, feedback = top bit XOR data bit.
    function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] b);
        logic fb;
        for (int j = 7; j >= 0; j--) begin
            fb = c[31] ^ b[j];
            c  = c << 1;
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    task automatic chk(string tag, logic [31:0] exp);
        n_chk++;
        if (crc_u !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, crc_u, exp);
        end
        n_chk++;
        if (crc_t !== exp) begin
            n_fail++;
            $display("FAIL R10 (%s, table variant): actual %08h expected %08h",
                     tag, crc_t, exp);
        end
    endtask

    // Apply inputs at a falling edge; return at the next falling edge.
    task automatic cyc(logic i, logic [31:0] iv, logic v, logic [7:0] b);
        init = i; init_val = iv; vld = v; data = b;
        @(negedge clk);
        init = 1'b0; vld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] exp;
        logic [31:0] saved;
        logic [31:0] iv;
        logic [7:0]  msg [64];
        int          len;
        int          cut;

        @(negedge clk);
        @(negedge clk);
        chk("R1 reset value", 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: published vector, after a bare load (R6).
        cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 8'h00);
        chk("R6 bare load", 32'hFFFF_FFFF);
        for (int k = 1; k <= 4; k++) cyc(1'b0, '0, 1'b1, 8'(k));
        chk("R4 vector 01..04", 32'hF33C_B7D3);

        // R6 with a non-default value.
        cyc(1'b1, 32'h1234_5678, 1'b0, 8'hAA);
        chk("R6 load value", 32'h1234_5678);

        // R2/R7: every byte value folded in on a load in the same cycle.
        for (int b = 0; b < 256; b++) begin
            cyc(1'b1, 32'hFFFF_FFFF, 1'b1, 8'(b));
            chk("R2 single byte from all-ones", ref_byte(32'hFFFF_FFFF, 8'(b)));
            iv = $urandom;
            cyc(1'b1, iv, 1'b1, 8'(b));
            chk("R7 load plus byte", ref_byte(iv, 8'(b)));
        end

        // R2: a zero byte on a zero value stays zero.
        cyc(1'b1, 32'h0, 1'b1, 8'h00);
        chk("R2 zero stays zero", 32'h0);

        // R3: back-to-back bytes, checked every cycle.
        cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 8'h00);
        exp = 32'hFFFF_FFFF;
        for (int k = 0; k < 300; k++) begin
            data = 8'($urandom);
            exp  = ref_byte(exp, data);
            cyc(1'b0, '0, 1'b1, data);
            chk("R3 streaming", exp);
        end

        // R5: idle cycles with a toggling bus and load value.
        for (int k = 0; k < 20; k++) begin
            cyc(1'b0, $urandom, 1'b0, 8'($urandom));
            chk("R5 hold", exp);
        end

        // R8/R9: random messages, including zero length, split and resumed.
        for (int m = 0; m < 120; m++) begin
            len = (m < 5) ? 0 : ($urandom % 64);
            iv  = (m % 2 == 0) ? 32'hFFFF_FFFF : $urandom;
            for (int k = 0; k < len; k++) msg[k] = 8'($urandom);
            cyc(1'b1, iv, 1'b0, 8'h00);
            exp = iv;
            for (int k = 0; k < len; k++) begin
                exp = ref_byte(exp, msg[k]);
                cyc(1'b0, '0, 1'b1, msg[k]);
            end
            if (len == 0) begin
                cyc(1'b0, '0, 1'b0, 8'h5A);
                chk("R9 zero-length equals load", iv);
            end else begin
                chk("R3 message result", exp);
                cut = $urandom % len;
                saved = iv;
                for (int k = 0; k < cut; k++) saved = ref_byte(saved, msg[k]);
                // Disturb the register with an unrelated message.
                cyc(1'b1, $urandom, 1'b1, 8'($urandom));
                cyc(1'b0, '0, 1'b1, 8'($urandom));
                // Resume from the saved value with the remaining bytes.
                cyc(1'b1, saved, 1'b0, 8'h00);
                for (int k = cut; k < len; k++) cyc(1'b0, '0, 1'b1, msg[k]);
                chk("R8 resumed stream", exp);
            end
        end

        // R1: reset in mid-stream restores the default value.
        cyc(1'b0, '0, 1'b1, 8'h77);
        rst_n = 1'b0;
        cyc(1'b0, '0, 1'b1, 8'h33);
        chk("R1 reset mid-stream", 32'hFFFF_FFFF);
        rst_n = 1'b1;

        finish_run();
    end

endmodule